// File: doc/BRIEF.md
# Armed Configuration-Read Redirect

This block sits on the result path of a CPU's program-memory load instruction. Normally a load returns the program-memory data word unchanged. Software can arm a one-shot detour by writing a control byte. If a load instruction then executes within a short window of cycles, the block returns a configuration byte instead of memory data.

The detour has two modes. Fuse/lock mode returns fuse and lock bytes. Signature mode returns the factory signature bytes and the oscillator calibration byte. The low bits of the load pointer pick the byte. Configuration inputs give programmed bits as 1, and the block presents them inverted, so a programmed bit reads 0 and an unprogrammed bit reads 1.

The arming ends after one redirected load. It also ends without notice when the window runs out.

Top module: `cfg_read_redirect`

## Requirements
- R1: After reset the block is disarmed, and every load returns `pmem_rdata`.
- R2: The control write byte is decoded as follows:
  - bit 0 is the enable bit, bit 1 selects fuse/lock mode, and bit 2 selects signature mode.
  - A write with bit 0 and one mode bit set arms that mode.
  - Any other write disarms the block.
- R3: A write that sets bit 0 together with both mode bits arms signature mode.
- R4: A load is redirected when it executes in any of the 3 cycles that follow the arming write cycle. A load in the arming write cycle itself uses the earlier state.
- R5: If no load executes in those 3 cycles, the block disarms, and a later load returns `pmem_rdata`.
- R6: One redirected load disarms the block, and the next load returns `pmem_rdata`.
- R7: An arming write while the block is already armed restarts the 3-cycle window from the beginning.
- R8: In fuse/lock mode, the selector picks the byte, and each returned bit is the inverse of its programmed flag:
  - selector 0 returns the low fuse byte.
  - selector 1 returns the lock byte.
  - selector 3 returns the high fuse byte.
  - selectors 4 to 7 return 0xFF.
- R9: In fuse/lock mode, selector 2 returns the extended fuse byte. Bits 2:0 are the inverted extended fuse flags, and bits 7:3 read 1.
- R10: In signature mode, the selector picks the byte:
  - selector 0 returns signature byte 1.
  - selector 1 returns the calibration byte.
  - selector 2 returns signature byte 2.
  - selector 4 returns signature byte 3.
  - selectors 3, 5, 6 and 7 are reserved and return 0xFF.
- R11: Only pointer bits 2:0 form the selector, and pointer bits 15:3 are ignored. For example, 0x0008 reads the same byte as 0x0000.
- R12: While disarmed, or when no load executes, `ld_result` equals `pmem_rdata` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data (bit 0 enable, bit 1 fuse/lock, bit 2 signature) |
| ld_strobe | input | 1 | A program-memory load executes this cycle |
| ld_ptr | input | 16 | Load address pointer |
| pmem_rdata | input | 8 | Program-memory read data |
| fuse_lo_pgm | input | 8 | Low fuse programmed flags (1 = programmed) |
| fuse_hi_pgm | input | 8 | High fuse programmed flags |
| fuse_ext_pgm | input | 3 | Extended fuse programmed flags |
| lock_pgm | input | 8 | Lock bit programmed flags |
| sig_b1 | input | 8 | Signature byte 1 |
| sig_b2 | input | 8 | Signature byte 2 |
| sig_b3 | input | 8 | Signature byte 3 |
| osc_cal | input | 8 | Oscillator calibration byte |
| ld_result | output | 8 | Load result (combinational) |

## Verification
Directed sequences place a load at each cycle offset from the arming write. Offsets 0 to 4 separate the write-cycle case, the three valid window slots and expiry. Back-to-back loads separate one-shot behaviour from a sticky mode. Repeated writes separate a restarted window from a window that keeps counting. Random traffic then mixes writes of all control patterns with loads at random pointers, including high pointer bits, and every cycle is compared with a bench model, so mode priority, every selector value in both modes and aliasing are each exercised many times.

// File: rtl/cfg_read_redirect.sv
module cfg_read_redirect #(
  parameter int WINDOW   = 3,
  parameter int PTR_W    = 16,
  parameter int SEL_W    = 3,
  parameter int EN_BIT   = 0,
  parameter int FUSE_BIT = 1,
  parameter int SIG_BIT  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             ld_strobe,
  input  logic [PTR_W-1:0] ld_ptr,
  input  logic [7:0]       pmem_rdata,
  input  logic [7:0]       fuse_lo_pgm,
  input  logic [7:0]       fuse_hi_pgm,
  input  logic [2:0]       fuse_ext_pgm,
  input  logic [7:0]       lock_pgm,
  input  logic [7:0]       sig_b1,
  input  logic [7:0]       sig_b2,
  input  logic [7:0]       sig_b3,
  input  logic [7:0]       osc_cal,
  output logic [7:0]       ld_result
);

  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  logic             arm_fuse, arm_sig;
  logic [CNT_W-1:0] win_cnt;
  logic [7:0]       fuse_byte, sig_byte;
  logic [SEL_W-1:0] sel;

  wire armed    = arm_fuse | arm_sig;
  wire set_sig  = ctl_wdata[EN_BIT] & ctl_wdata[SIG_BIT];
  wire set_fuse = ctl_wdata[EN_BIT] & ctl_wdata[FUSE_BIT] & ~ctl_wdata[SIG_BIT];

  assign sel = ld_ptr[SEL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_fuse <= 1'b0;
      arm_sig  <= 1'b0;
      win_cnt  <= '0;
    end else if (ctl_we) begin
      arm_sig  <= set_sig;
      arm_fuse <= set_fuse;
      win_cnt  <= '0;
    end else if (armed) begin
      if (ld_strobe || win_cnt == LAST) begin
        arm_fuse <= 1'b0;
        arm_sig  <= 1'b0;
        win_cnt  <= '0;
      end else begin
        win_cnt  <= win_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_W'(0): fuse_byte = ~fuse_lo_pgm;
      SEL_W'(1): fuse_byte = ~lock_pgm;
      SEL_W'(2): fuse_byte = {5'b11111, ~fuse_ext_pgm};
      SEL_W'(3): fuse_byte = ~fuse_hi_pgm;
      default:   fuse_byte = 8'hFF;
    endcase
  end

  always_comb begin
    case (sel)
      SEL_W'(0): sig_byte = sig_b1;
      SEL_W'(1): sig_byte = osc_cal;
      SEL_W'(2): sig_byte = sig_b2;
      SEL_W'(4): sig_byte = sig_b3;
      default:   sig_byte = 8'hFF;
    endcase
  end

  assign ld_result = (ld_strobe && arm_sig)  ? sig_byte  :
                     (ld_strobe && arm_fuse) ? fuse_byte : pmem_rdata;

endmodule

// File: rtl/cfg_read_redirect_chk.sv
module cfg_read_redirect_chk #(
  parameter int WINDOW   = 3,
  parameter int PTR_W    = 16,
  parameter int SEL_W    = 3,
  parameter int EN_BIT   = 0,
  parameter int FUSE_BIT = 1,
  parameter int SIG_BIT  = 2,
  parameter int CNT_W    = $clog2(WINDOW + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic             ld_strobe,
  input logic [PTR_W-1:0] ld_ptr,
  input logic [7:0]       pmem_rdata,
  input logic [7:0]       ld_result,
  input logic             arm_fuse,
  input logic             arm_sig,
  input logic [CNT_W-1:0] win_cnt
);

  wire armed  = arm_fuse | arm_sig;
  wire wr_arm = ctl_we && ctl_wdata[EN_BIT] && (ctl_wdata[FUSE_BIT] || ctl_wdata[SIG_BIT]);

  a_r2_single_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arm_fuse, arm_sig}));

  a_r3_sig_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[EN_BIT] && ctl_wdata[SIG_BIT] && ctl_wdata[FUSE_BIT])
    |=> (arm_sig && !arm_fuse));

  a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (int'(win_cnt) < WINDOW));

  a_r5_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ld_strobe && !ctl_we && int'(win_cnt) == WINDOW - 1) |=> !armed);

  a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && ld_strobe && !ctl_we) |=> !armed);

  a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
    wr_arm |=> (armed && win_cnt == '0));

  a_r9_ext_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_fuse && ld_strobe && ld_ptr[SEL_W-1:0] == SEL_W'(2)) |-> (ld_result[7:3] == 5'b11111));

  a_r12_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed || !ld_strobe) |-> (ld_result == pmem_rdata));

endmodule

bind cfg_read_redirect cfg_read_redirect_chk #(
  .WINDOW(WINDOW), .PTR_W(PTR_W), .SEL_W(SEL_W),
  .EN_BIT(EN_BIT), .FUSE_BIT(FUSE_BIT), .SIG_BIT(SIG_BIT)
) u_chk (.*);

// File: tb/test_cfg_read_redirect.sv
module test_cfg_read_redirect;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_we = 1'b0, ld_strobe = 1'b0;
  logic [7:0] ctl_wdata = '0, pmem_rdata = '0;
  logic [15:0] ld_ptr = '0;
  logic [7:0] fuse_lo_pgm, fuse_hi_pgm, lock_pgm, sig_b1, sig_b2, sig_b3, osc_cal;
  logic [2:0] fuse_ext_pgm;
  logic [7:0] ld_result;

  int errors = 0, checks = 0;
  int m_mode = 0, m_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cfg_read_redirect i_cfg_read_redirect (.*);

  function automatic logic [7:0] exp_val(input int mode, input logic ld, input logic [15:0] p);
    logic [2:0] s = p[2:0];
    if (!ld || mode == 0) return pmem_rdata;
    if (mode == 2) begin
      case (s)
        3'd0: return sig_b1;
        3'd1: return osc_cal;
        3'd2: return sig_b2;
        3'd4: return sig_b3;
        default: return 8'hFF;
      endcase
    end
    case (s)
      3'd0: return ~fuse_lo_pgm;
      3'd1: return ~lock_pgm;
      3'd2: return {5'b11111, ~fuse_ext_pgm};
      3'd3: return ~fuse_hi_pgm;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic string auto_tag(input int mode, input logic ld, input logic [15:0] p);
    if (!ld || mode == 0) return "R12";
    if (p[15:3] != 0) return "R11";
    if (mode == 2) return "R10";
    return (p[2:0] == 3'd2) ? "R9" : "R8";
  endfunction

  task automatic cyc(input logic we, input logic [7:0] wd, input logic ld,
                     input logic [15:0] p, input string tag);
    logic [7:0] e;
    string t;
    @(negedge clk);
    ctl_we = we; ctl_wdata = wd; ld_strobe = ld; ld_ptr = p;
    pmem_rdata = 8'($urandom);
    #1;
    e = exp_val(m_mode, ld, p);
    t = (tag == "") ? auto_tag(m_mode, ld, p) : tag;
    checks++;
    if (ld_result !== e) begin
      errors++;
      $display("FAIL %s: ld_result=%02h expected=%02h (ptr=%04h ld=%0b)", t, ld_result, e, p, ld);
    end
    @(posedge clk);
    if (we) begin
      m_cnt = 0;
      if (wd[0] && wd[2]) m_mode = 2;
      else if (wd[0] && wd[1]) m_mode = 1;
      else m_mode = 0;
    end else if (m_mode != 0) begin
      if (ld || m_cnt == 2) begin m_mode = 0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 8'h00, 1'b0, 16'h0000, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    fuse_lo_pgm = 8'h3C; fuse_hi_pgm = 8'hA1; lock_pgm = 8'h0F;
    fuse_ext_pgm = 3'b101; sig_b1 = 8'h1E; sig_b2 = 8'h95; sig_b3 = 8'h0F; osc_cal = 8'h6B;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state, loads pass through
    cyc(0, 0, 1, 16'h0000, "R1");
    cyc(0, 0, 1, 16'h0002, "R1");

    // R4: load in each window slot, and in the write cycle itself
    for (int off = 1; off <= 3; off++) begin
      cyc(1, 8'h05, 0, 0, "R2");
      for (int k = 1; k < off; k++) idle("R4");
      cyc(0, 0, 1, 16'h0000, "R4");
    end
    cyc(1, 8'h03, 1, 16'h0001, "R4");
    cyc(0, 0, 1, 16'h0001, "R4");

    // R5: expiry after three idle cycles
    cyc(1, 8'h05, 0, 0, "R2");
    repeat (3) idle("R5");
    cyc(0, 0, 1, 16'h0000, "R5");

    // R6: one-shot
    cyc(1, 8'h03, 0, 0, "R2");
    cyc(0, 0, 1, 16'h0002, "R9");
    cyc(0, 0, 1, 16'h0002, "R6");

    // R7: restart on rearm
    cyc(1, 8'h05, 0, 0, "R2");
    idle("R7"); idle("R7");
    cyc(1, 8'h05, 0, 0, "R7");
    idle("R7"); idle("R7");
    cyc(0, 0, 1, 16'h0004, "R7");

    // R3: both mode bits, signature wins
    cyc(1, 8'h07, 0, 0, "R3");
    cyc(0, 0, 1, 16'h0001, "R3");

    // R2: enable missing disarms, mode bits missing disarms
    cyc(1, 8'h03, 0, 0, "R2");
    cyc(1, 8'h02, 0, 0, "R2");
    cyc(0, 0, 1, 16'h0000, "R2");
    cyc(1, 8'h01, 0, 0, "R2");
    cyc(0, 0, 1, 16'h0000, "R2");

    // R8 / R10: every selector in both modes
    for (int s = 0; s < 8; s++) begin
      cyc(1, 8'h03, 0, 0, "R8");
      cyc(0, 0, 1, 16'(s), (s == 2) ? "R9" : "R8");
      cyc(1, 8'h05, 0, 0, "R10");
      cyc(0, 0, 1, 16'(s), "R10");
    end

    // R11: high pointer bits ignored
    cyc(1, 8'h05, 0, 0, "R11");
    cyc(0, 0, 1, 16'h0008, "R11");
    cyc(1, 8'h03, 0, 0, "R11");
    cyc(0, 0, 1, 16'hFFFA, "R11");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] wd;
      logic we, ld;
      case ($urandom_range(0, 5))
        0: wd = 8'h03; 1: wd = 8'h05; 2: wd = 8'h07;
        3: wd = 8'h01; 4: wd = 8'h06; default: wd = 8'($urandom);
      endcase
      we = ($urandom_range(0, 3) == 0);
      ld = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 199) == 0) begin
        fuse_lo_pgm = 8'($urandom); lock_pgm = 8'($urandom);
        fuse_ext_pgm = 3'($urandom); sig_b2 = 8'($urandom);
      end
      cyc(we, wd, ld, ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 7)), "");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule